// File: doc/BRIEF.md
# Double-Word Atomic Staging Sequencer

This unit lets a 32-bit processor perform 64-bit linked-load and store-conditional operations. Two 32-bit staging registers, an upper and a lower word, hold one 64-bit value. Software can write either word directly and can observe both at all times. A write to one of the two operation codes supplies a virtual address and starts an atomic sequence. The unit requests a translation, forces the physical address to a double-word boundary and issues one 64-bit memory transaction. It then writes the result back into the staging registers.

A linked load replaces both staging words with the 64 bits that the memory returns. A store conditional sends the current staging pair as its data. The status that comes back replaces only the lower word. The processor is stalled from the cycle after the starting write until the sequence returns to idle. A translation fault ends the sequence early, raises a fault flag and issues no memory transaction.

Top module: `lldsc_unit`

## Requirements
- R1: In idle, a write with `wr_op` = 0 loads `wr_data` into `word_hi`, and `wr_op` = 1 loads it into `word_lo`. The new value is visible the cycle after the write.
- R2: A write with `wr_op` = 2 (linked load) or `wr_op` = 3 (store conditional) starts a sequence. The next cycle, `xlat_req` is high with `xlat_vaddr` equal to `wr_data` with its three lowest bits cleared.
- R3: After a translation accepted without fault, `mem_req` is raised with `mem_addr` equal to the returned physical address with its three lowest bits cleared. `mem_is_sc` is 1 for a store conditional and 0 for a linked load.
- R4: When a linked load completes, `word_hi` holds `mem_rsp_data[63:32]` and `word_lo` holds `mem_rsp_data[31:0]`.
- R5: During a store conditional, `mem_wdata` equals {`word_hi`, `word_lo`} as they stood when the sequence started.
- R6: When a store conditional completes, `word_lo` holds the status in `mem_rsp_data[31:0]` (zero means success) and `word_hi` is unchanged.
- R7: `stall` is high from the cycle after a starting write through the write-back cycle. It is low in idle.
- R8: A faulting translation returns the unit to idle on the next cycle with `fault` = 1, no memory request and both staging words unchanged. `fault` clears when the next sequence starts.
- R9: Register writes presented while `stall` is high have no effect.
- R10: While `mem_req` is high and `mem_gnt` is low, the request and its address stay unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_op | input | 2 | 0 upper word, 1 lower word, 2 linked load, 3 store conditional |
| wr_data | input | 32 | Write data or virtual address |
| word_hi | output | 32 | Upper staging word |
| word_lo | output | 32 | Lower staging word |
| stall | output | 1 | Processor stall |
| fault | output | 1 | Last sequence ended in a translation fault |
| xlat_req | output | 1 | Translation request |
| xlat_vaddr | output | 32 | Aligned virtual address to translate |
| xlat_ack | input | 1 | Translation response valid |
| xlat_fault | input | 1 | Translation failed |
| xlat_paddr | input | 40 | Translated physical address |
| mem_req | output | 1 | Memory transaction request |
| mem_is_sc | output | 1 | 1 store conditional, 0 linked load |
| mem_addr | output | 40 | Aligned physical address |
| mem_wdata | output | 64 | Store-conditional data |
| mem_gnt | input | 1 | Memory accepted the request |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_data | input | 64 | Load data, or status in the lower 32 bits |

## Verification
The assertions assume that the translation and memory sides answer only what was asked. `xlat_ack` arrives only while `xlat_req` is high, `mem_gnt` only while `mem_req` is high, and `mem_rsp_valid` only after a grant. The bench responders drive each handshake strobe for exactly one cycle, and only after they see the matching request. Random latencies, addresses, data and fault choices vary within these rules. Writes made during a stall are driven on purpose to probe R9.

// File: rtl/lldsc_pkg.sv
package lldsc_pkg;
    localparam int ALIGN_BITS = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XLAT,
        ST_ISSUE,
        ST_WAIT,
        ST_WB
    } lldsc_state_e;

    typedef enum logic [1:0] {
        OP_SET_HI = 2'd0,
        OP_SET_LO = 2'd1,
        OP_LL     = 2'd2,
        OP_SC     = 2'd3
    } lldsc_op_e;
endpackage

// File: rtl/lldsc_seq.sv
module lldsc_seq
    import lldsc_pkg::*;
#(
    parameter int VA_W = 32,
    parameter int PA_W = 40,
    parameter int DDW  = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            start_is_sc,
    input  logic [VA_W-1:0] start_vaddr,
    output logic            busy,
    output logic            fault,
    output logic            xlat_req,
    output logic [VA_W-1:0] xlat_vaddr,
    input  logic            xlat_ack,
    input  logic            xlat_fault,
    input  logic [PA_W-1:0] xlat_paddr,
    output logic            mem_req,
    output logic            mem_is_sc,
    output logic [PA_W-1:0] mem_addr,
    input  logic            mem_gnt,
    input  logic            mem_rsp_valid,
    input  logic [DDW-1:0]  mem_rsp_data,
    output logic            wb_en,
    output logic            wb_is_sc,
    output logic [DDW-1:0]  wb_data
);
    typedef struct packed {
        lldsc_state_e    st;
        logic            is_sc;
        logic            fault;
        logic [VA_W-1:0] vaddr;
        logic [PA_W-1:0] paddr;
        logic [DDW-1:0]  rdata;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st    = ST_XLAT;
                    s_d.is_sc = start_is_sc;
                    s_d.fault = 1'b0;
                    s_d.vaddr = {start_vaddr[VA_W-1:ALIGN_BITS], ALIGN_BITS'(0)};
                end
            end
            ST_XLAT: begin
                if (xlat_ack) begin
                    if (xlat_fault) begin
                        s_d.st    = ST_IDLE;
                        s_d.fault = 1'b1;
                    end else begin
                        s_d.st    = ST_ISSUE;
                        s_d.paddr = {xlat_paddr[PA_W-1:ALIGN_BITS], ALIGN_BITS'(0)};
                    end
                end
            end
            ST_ISSUE: if (mem_gnt) s_d.st = ST_WAIT;
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    s_d.st    = ST_WB;
                    s_d.rdata = mem_rsp_data;
                end
            end
            ST_WB:   s_d.st = ST_IDLE;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign busy       = (s_q.st != ST_IDLE);
    assign fault      = s_q.fault;
    assign xlat_req   = (s_q.st == ST_XLAT);
    assign xlat_vaddr = s_q.vaddr;
    assign mem_req    = (s_q.st == ST_ISSUE);
    assign mem_is_sc  = s_q.is_sc;
    assign mem_addr   = s_q.paddr;
    assign wb_en      = (s_q.st == ST_WB);
    assign wb_is_sc   = s_q.is_sc;
    assign wb_data    = s_q.rdata;
endmodule

// File: rtl/lldsc_stage.sv
module lldsc_stage #(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_hi,
    input  logic            set_lo,
    input  logic [DW-1:0]   set_data,
    input  logic            wb_en,
    input  logic            wb_is_sc,
    input  logic [2*DW-1:0] wb_data,
    output logic [DW-1:0]   hi,
    output logic [DW-1:0]   lo
);
    typedef struct packed {
        logic [DW-1:0] hi;
        logic [DW-1:0] lo;
    } stage_t;

    stage_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (set_hi) r_d.hi = set_data;
        if (set_lo) r_d.lo = set_data;
        if (wb_en) begin
            r_d.lo = wb_data[DW-1:0];
            if (!wb_is_sc) r_d.hi = wb_data[2*DW-1:DW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign hi = r_q.hi;
    assign lo = r_q.lo;
endmodule

// File: rtl/lldsc_unit.sv
module lldsc_unit
    import lldsc_pkg::*;
#(
    parameter int DW   = 32,
    parameter int VA_W = 32,
    parameter int PA_W = 40,
    localparam int DDW = 2 * DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      wr_op,
    input  logic [DW-1:0]   wr_data,
    output logic [DW-1:0]   word_hi,
    output logic [DW-1:0]   word_lo,
    output logic            stall,
    output logic            fault,
    output logic            xlat_req,
    output logic [VA_W-1:0] xlat_vaddr,
    input  logic            xlat_ack,
    input  logic            xlat_fault,
    input  logic [PA_W-1:0] xlat_paddr,
    output logic            mem_req,
    output logic            mem_is_sc,
    output logic [PA_W-1:0] mem_addr,
    output logic [DDW-1:0]  mem_wdata,
    input  logic            mem_gnt,
    input  logic            mem_rsp_valid,
    input  logic [DDW-1:0]  mem_rsp_data
);
    logic            busy, accept, start, set_hi, set_lo;
    logic            wb_en, wb_is_sc;
    logic [DDW-1:0]  wb_data;
    logic [VA_W-1:0] start_vaddr;

    assign accept      = wr_en && !busy;
    assign start       = accept && (wr_op == OP_LL || wr_op == OP_SC);
    assign set_hi      = accept && (wr_op == OP_SET_HI);
    assign set_lo      = accept && (wr_op == OP_SET_LO);
    assign start_vaddr = VA_W'(wr_data);

    lldsc_seq #(.VA_W(VA_W), .PA_W(PA_W), .DDW(DDW)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(start), .start_is_sc(wr_op == OP_SC), .start_vaddr(start_vaddr),
        .busy(busy), .fault(fault),
        .xlat_req(xlat_req), .xlat_vaddr(xlat_vaddr),
        .xlat_ack(xlat_ack), .xlat_fault(xlat_fault), .xlat_paddr(xlat_paddr),
        .mem_req(mem_req), .mem_is_sc(mem_is_sc), .mem_addr(mem_addr),
        .mem_gnt(mem_gnt), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .wb_en(wb_en), .wb_is_sc(wb_is_sc), .wb_data(wb_data)
    );

    lldsc_stage #(.DW(DW)) u_stage (
        .clk(clk), .rst_n(rst_n),
        .set_hi(set_hi), .set_lo(set_lo), .set_data(wr_data),
        .wb_en(wb_en), .wb_is_sc(wb_is_sc), .wb_data(wb_data),
        .hi(word_hi), .lo(word_lo)
    );

    assign stall     = busy;
    assign mem_wdata = {word_hi, word_lo};
endmodule

// File: rtl/lldsc_unit_chk.sv
module lldsc_unit_chk #(
    parameter int DW   = 32,
    parameter int VA_W = 32,
    parameter int PA_W = 40
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [DW-1:0]   word_hi,
    input logic [DW-1:0]   word_lo,
    input logic            stall,
    input logic            fault,
    input logic            xlat_req,
    input logic            xlat_ack,
    input logic            xlat_fault,
    input logic [VA_W-1:0] xlat_vaddr,
    input logic            mem_req,
    input logic [PA_W-1:0] mem_addr,
    input logic            mem_gnt
);
    a_r2_vaddr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_req |-> (xlat_vaddr[2:0] == 3'b000));

    a_r3_paddr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[2:0] == 3'b000));

    a_r7_busy_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (xlat_req || mem_req) |-> stall);

    a_r8_fault_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (xlat_req && xlat_ack && xlat_fault) |=> (!mem_req && !stall && fault));

    a_r9_idle_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !wr_en) |=> ($stable(word_hi) && $stable(word_lo)));

    a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));
endmodule

bind lldsc_unit lldsc_unit_chk #(.DW(DW), .VA_W(VA_W), .PA_W(PA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .word_hi(word_hi), .word_lo(word_lo), .stall(stall), .fault(fault),
    .xlat_req(xlat_req), .xlat_ack(xlat_ack), .xlat_fault(xlat_fault),
    .xlat_vaddr(xlat_vaddr), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_gnt(mem_gnt)
);

// File: tb/lldsc_unit_test.sv
module lldsc_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_op = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] word_hi, word_lo, xlat_vaddr;
    logic        stall, fault, xlat_req, mem_req, mem_is_sc;
    logic        xlat_ack = 1'b0, xlat_fault = 1'b0;
    logic [39:0] xlat_paddr = '0, mem_addr;
    logic [63:0] mem_wdata;
    logic        mem_gnt = 1'b0, mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    int n_chk = 0, n_fail = 0;
    logic [31:0] exp_hi = '0, exp_lo = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lldsc_unit uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_op(wr_op), .wr_data(wr_data),
        .word_hi(word_hi), .word_lo(word_lo), .stall(stall), .fault(fault),
        .xlat_req(xlat_req), .xlat_vaddr(xlat_vaddr), .xlat_ack(xlat_ack),
        .xlat_fault(xlat_fault), .xlat_paddr(xlat_paddr),
        .mem_req(mem_req), .mem_is_sc(mem_is_sc), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    function automatic logic [31:0] va_align(input logic [31:0] a);
        return {a[31:3], 3'b000};
    endfunction
    function automatic logic [39:0] pa_align(input logic [39:0] a);
        return {a[39:3], 3'b000};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] op, input logic [31:0] d);
        wr_en = 1'b1; wr_op = op; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_op(input bit sc, input logic [31:0] va, input bit flt, input int lat);
        logic [31:0] hi0 = exp_hi, lo0 = exp_lo;
        logic [39:0] pa = {$urandom, $urandom};
        logic [63:0] rd = {$urandom, $urandom};
        reg_write(sc ? 2'd3 : 2'd2, va);
        check(stall === 1'b1, "R7 stall after start", 64'(stall), 64'd1);
        check(xlat_req === 1'b1 && xlat_vaddr === va_align(va), "R2 translate request",
              64'(xlat_vaddr), 64'(va_align(va)));
        for (int i = 0; i < lat; i++) begin
            reg_write(2'd0, $urandom);
            check(word_hi === hi0, "R9 write during stall ignored", 64'(word_hi), 64'(hi0));
        end
        xlat_ack = 1'b1; xlat_fault = flt; xlat_paddr = pa;
        @(negedge clk);
        xlat_ack = 1'b0; xlat_fault = 1'b0;
        if (flt) begin
            check(stall === 1'b0 && fault === 1'b1 && mem_req === 1'b0, "R8 fault abort",
                  {61'd0, stall, fault, mem_req}, 64'h2);
            check(word_hi === hi0 && word_lo === lo0, "R8 regs unchanged",
                  {word_hi, word_lo}, {hi0, lo0});
            return;
        end
        check(mem_req === 1'b1 && mem_addr === pa_align(pa), "R3 mem address",
              64'(mem_addr), 64'(pa_align(pa)));
        check(mem_is_sc === sc, "R3 op kind", 64'(mem_is_sc), 64'(sc));
        if (sc) check(mem_wdata === {hi0, lo0}, "R5 sc data", mem_wdata, {hi0, lo0});
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            check(mem_req === 1'b1 && mem_addr === pa_align(pa), "R10 request held",
                  64'(mem_addr), 64'(pa_align(pa)));
        end
        mem_gnt = 1'b1;
        @(negedge clk);
        mem_gnt = 1'b0;
        check(mem_req === 1'b0 && stall === 1'b1, "R7 stall while waiting", 64'(stall), 64'd1);
        for (int i = 0; i < lat; i++) @(negedge clk);
        if (sc) rd[31:0] = 32'($urandom_range(0, 1));
        mem_rsp_valid = 1'b1; mem_rsp_data = rd;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        check(stall === 1'b1, "R7 stall in write-back", 64'(stall), 64'd1);
        @(negedge clk);
        check(stall === 1'b0 && fault === 1'b0, "R7 idle after op / R8 fault cleared",
              {62'd0, stall, fault}, 64'd0);
        if (sc) begin
            exp_lo = rd[31:0];
            check(word_hi === hi0, "R6 hi kept", 64'(word_hi), 64'(hi0));
            check(word_lo === exp_lo, "R6 status in lo", 64'(word_lo), 64'(exp_lo));
        end else begin
            exp_hi = rd[63:32]; exp_lo = rd[31:0];
            check({word_hi, word_lo} === rd, "R4 ll data", {word_hi, word_lo}, rd);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=done", WATCHDOG);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(stall === 1'b0 && fault === 1'b0 && xlat_req === 1'b0 && mem_req === 1'b0,
              "R7 reset idle", {60'd0, stall, fault, xlat_req, mem_req}, 64'd0);
        check(word_hi === 32'd0 && word_lo === 32'd0, "R1 reset regs", {word_hi, word_lo}, 64'd0);
        exp_hi = 32'hDEAD_BEEF; exp_lo = 32'h0123_4567;
        reg_write(2'd0, exp_hi);
        reg_write(2'd1, exp_lo);
        check(word_hi === exp_hi && word_lo === exp_lo, "R1 direct write",
              {word_hi, word_lo}, {exp_hi, exp_lo});
        run_op(1'b0, 32'h1000_0007, 1'b0, 0);
        run_op(1'b1, 32'hFFFF_FFFF, 1'b0, 2);
        run_op(1'b1, 32'h0000_0004, 1'b1, 1);
        run_op(1'b0, 32'h8000_0003, 1'b1, 0);
        for (int k = 0; k < 60; k++) begin
            if ($urandom_range(0, 3) == 0) begin
                if ($urandom_range(0, 1) == 0) begin exp_hi = $urandom; reg_write(2'd0, exp_hi); end
                else begin exp_lo = $urandom; reg_write(2'd1, exp_lo); end
                check(word_hi === exp_hi && word_lo === exp_lo, "R1 random write",
                      {word_hi, word_lo}, {exp_hi, exp_lo});
            end
            run_op(1'($urandom_range(0, 1)), $urandom, ($urandom_range(0, 4) == 0),
                   int'($urandom_range(0, 3)));
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule